// File: doc/BRIEF.md
# Thermal and Overcurrent Fault Manager

This block sits between the temperature and current sensing of a power output stage and its gate controller. Each clock it takes an unsigned die-temperature code in whole degrees Celsius, a flag from the current sensor and a mute request. From these it keeps two thermal fault flags and one overcurrent fault, and it drives a single output-disable line that tells the gate controller to switch all power transistors off.

The thermal faults have hysteresis and recover on their own. The warning flag rises above one threshold and the shutdown flag rises above a higher one. Both fall together once the temperature drops below a common release threshold. The overcurrent fault is sticky. Once it is set, only a synchronous reset or a full mute cycle clears it: mute is raised and later dropped, and the latch clears on the clock edge where the drop is seen. The fault flags leave the block active-low, and each comes straight from a flip-flop.

Top module: `fault_mgr`

## Requirements
- R1: `therm_warn_n` goes low one clock after a clock edge that samples `temp_c` strictly greater than `WARN_ABOVE` (135 by default). A value equal to 135 does not set it.
- R2: `therm_shut_n` goes low one clock after a clock edge that samples `temp_c` strictly greater than `SHUT_ABOVE` (150 by default), and `out_disable` is high while it is low. A value equal to 150 does not set it.
- R3: Both thermal flags return high one clock after a clock edge that samples `temp_c` strictly below `CLEAR_BELOW` (120 by default). A value of exactly 120 does not clear them.
- R4: While `temp_c` lies from `CLEAR_BELOW` to the flag's own assert threshold, both ends included, each thermal flag keeps its previous value.
- R5: A clock edge that samples `oc_detect` high makes `oc_err_n` low from the next cycle, so `out_disable` is high from then on. The exception is the edge that completes a mute release (R7).
- R6: Once set, `oc_err_n` stays low after `oc_detect` returns low. Raising `mute_req` and holding it high does not clear the latch.
- R7: The overcurrent latch clears on a clock edge that samples `mute_req` low when the previous edge sampled it high. `oc_err_n` is high from the next cycle.
- R8: If `oc_detect` is still high at the edge that completes the mute release, the latch clears at that edge and sets again at the following edge.
- R9: `out_disable` is high in the same cycle that `mute_req` is high, and it is high whenever thermal shutdown or the overcurrent latch is active. Otherwise it is low.
- R10: A clock edge with `rst_n` low clears every fault. From the next cycle all three flag outputs are high, `out_disable` follows only `mute_req`, and the mute history is cleared, so a mute that was high during reset does not count as a release after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_c | input | TEMP_W (8) | Die temperature, unsigned, whole degrees Celsius |
| oc_detect | input | 1 | High while the current sensor reports current above its limit |
| mute_req | input | 1 | Mute request, high to mute |
| therm_warn_n | output | 1 | Thermal warning, active low, registered |
| therm_shut_n | output | 1 | Thermal shutdown, active low, registered |
| oc_err_n | output | 1 | Latched overcurrent error, active low, registered |
| out_disable | output | 1 | High to force all power transistors off |

## Verification
The temperature is placed on each threshold and one degree to either side. This separates strict from inclusive comparisons at 135, 150 and 120. A slow rise and fall across the whole band then shows that the flags hold inside the hysteresis band and do not chatter. For the overcurrent path the bench uses a short current pulse, a mute that is held without being released, a release while the current is still present, and a mute that is high through reset. These cases separate set priority, clear priority, edge detection on the release, and the reset of the mute history. Mute on its own is also applied with no fault present, to show that the disable path is combinational.

// File: rtl/fault_mgr_pkg.sv
// fault_mgr_pkg: types shared by the fault manager.
// Assumes: exactly two thermal flags, in the order warning then shutdown.
package fault_mgr_pkg;
    typedef enum logic [0:0] {
        THERM_WARN = 1'b0,
        THERM_SHUT = 1'b1
    } therm_sel_e;

    localparam int unsigned THERM_COUNT = 2;
endpackage

// File: rtl/thermal_hyst.sv
// thermal_hyst: a registered comparator with hysteresis on a temperature code.
// The flag sets when the temperature is above ON_ABOVE, clears when it is
// below OFF_BELOW, and holds in between.
// Assumes: OFF_BELOW < ON_ABOVE and both fit in TEMP_W bits.
module thermal_hyst #(
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned ON_ABOVE  = 135,
    parameter int unsigned OFF_BELOW = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_c,
    output logic              flag
);
    localparam logic [TEMP_W-1:0] ON_CODE  = ON_ABOVE[TEMP_W-1:0];
    localparam logic [TEMP_W-1:0] OFF_CODE = OFF_BELOW[TEMP_W-1:0];

    logic above_on;
    logic below_off;

    // Compare the sampled code against both thresholds.
    always_comb begin
        above_on  = (temp_c > ON_CODE);
        below_off = (temp_c < OFF_CODE);
    end

    // Hysteresis register: set above, clear below, hold in the band.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (above_on)   flag <= 1'b1;
        else if (below_off)  flag <= 1'b0;
    end

    // R1 for the warning instance, R2 for the shutdown instance.
    a_r1_set_above: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c > ON_CODE) |=> flag);

    a_r3_release_below: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c < OFF_CODE) |=> !flag);

    a_r4_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c >= OFF_CODE && temp_c <= ON_CODE) |=> $stable(flag));
endmodule

// File: rtl/oc_latch.sv
// oc_latch: a sticky overcurrent fault.
// It sets on a sampled detect and clears on reset or when a mute that was
// high at the previous edge is sampled low. The clear wins over the set.
// Assumes: mute_req is synchronous to clk.
module oc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_detect,
    input  logic mute_req,
    output logic latched
);
    logic mute_q;
    logic mute_release;

    // Find the clock edge at which a held mute is dropped.
    always_comb mute_release = mute_q & ~mute_req;

    // Remember the mute level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mute_q <= 1'b0;
        else        mute_q <= mute_req;
    end

    // Fault latch: the release clears it, a detect sets it, otherwise it holds.
    always_ff @(posedge clk) begin
        if (!rst_n)            latched <= 1'b0;
        else if (mute_release) latched <= 1'b0;
        else if (oc_detect)    latched <= 1'b1;
    end

    a_r5_set_on_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_detect && !(mute_q && !mute_req)) |=> latched);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !(mute_q && !mute_req)) |=> latched);

    a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_q && !mute_req) |=> !latched);

    a_r8_reset_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_q && !mute_req && oc_detect) ##1 oc_detect |=> latched);
endmodule

// File: rtl/fault_mgr.sv
// fault_mgr: combines two thermal flags and a sticky overcurrent fault into
// active-low fault pins and one output-disable line for the gate controller.
// Assumes: the temperature code and the sensor flags are synchronous to clk.
// out_disable is an OR of registered faults and the mute request, so a mute
// request takes effect in the same cycle.
module fault_mgr #(
    parameter int unsigned TEMP_W      = 8,
    parameter int unsigned WARN_ABOVE  = 135,
    parameter int unsigned SHUT_ABOVE  = 150,
    parameter int unsigned CLEAR_BELOW = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic              oc_detect,
    input  logic              mute_req,
    output logic              therm_warn_n,
    output logic              therm_shut_n,
    output logic              oc_err_n,
    output logic              out_disable
);
    import fault_mgr_pkg::*;

    logic [THERM_COUNT-1:0] therm_flag;
    logic                   oc_flag;

    // One hysteresis comparator per thermal flag, each with its own threshold.
    for (genvar gi = 0; gi < THERM_COUNT; gi++) begin : g_therm
        localparam int unsigned ON_TH = (gi == int'(THERM_SHUT)) ? SHUT_ABOVE : WARN_ABOVE;
        thermal_hyst #(
            .TEMP_W   (TEMP_W),
            .ON_ABOVE (ON_TH),
            .OFF_BELOW(CLEAR_BELOW)
        ) u_hyst (
            .clk   (clk),
            .rst_n (rst_n),
            .temp_c(temp_c),
            .flag  (therm_flag[gi])
        );
    end

    oc_latch u_oc (
        .clk      (clk),
        .rst_n    (rst_n),
        .oc_detect(oc_detect),
        .mute_req (mute_req),
        .latched  (oc_flag)
    );

    // Drive the active-low pins from the flags and combine the disable sources.
    always_comb begin
        therm_warn_n = ~therm_flag[THERM_WARN];
        therm_shut_n = ~therm_flag[THERM_SHUT];
        oc_err_n     = ~oc_flag;
        out_disable  = therm_flag[THERM_SHUT] | oc_flag | mute_req;
    end

    a_r2_shut_implies_warn: assert property (@(posedge clk) disable iff (!rst_n)
        !therm_shut_n |-> !therm_warn_n);

    a_r2_shut_disables: assert property (@(posedge clk) disable iff (!rst_n)
        !therm_shut_n |-> out_disable);

    a_r9_mute_disables: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |-> out_disable);

    a_r5_detect_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_detect && mute_req) |=> out_disable);
endmodule

// File: tb/fault_mgr_bench.sv
// fault_mgr_bench: a behavioural reference model, compared at every clock.
module fault_mgr_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp_c = 8'd25;
    logic       oc_detect = 1'b0;
    logic       mute_req = 1'b0;
    logic       therm_warn_n, therm_shut_n, oc_err_n, out_disable;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state
    bit m_warn = 0, m_shut = 0, m_oc = 0, m_mute_prev = 0;

    always #(PERIOD/2) clk = ~clk;

    fault_mgr u_fault_mgr (
        .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .oc_detect(oc_detect),
        .mute_req(mute_req), .therm_warn_n(therm_warn_n),
        .therm_shut_n(therm_shut_n), .oc_err_n(oc_err_n),
        .out_disable(out_disable)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Apply inputs, clock once, advance the model, then compare at the falling edge.
    task automatic step(input bit rst, input int t, input bit oc, input bit mute, input string tag);
        rst_n     = rst;
        temp_c    = 8'(t);
        oc_detect = oc;
        mute_req  = mute;
        @(posedge clk);
        if (!rst) begin
            m_warn = 0; m_shut = 0; m_oc = 0; m_mute_prev = 0;
        end else begin
            if (t > 135) m_warn = 1; else if (t < 120) m_warn = 0;
            if (t > 150) m_shut = 1; else if (t < 120) m_shut = 0;
            if (m_mute_prev && !mute) m_oc = 0; else if (oc) m_oc = 1;
            m_mute_prev = mute;
        end
        @(negedge clk);
        check(tag, "therm_warn_n", therm_warn_n, !m_warn);
        check(tag, "therm_shut_n", therm_shut_n, !m_shut);
        check(tag, "oc_err_n", oc_err_n, !m_oc);
        check(tag, "out_disable", out_disable, m_shut | m_oc | mute_req);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset state
        step(0, 25, 0, 0, "R10");
        step(0, 200, 1, 1, "R10");
        step(1, 25, 0, 0, "R10");   // mute high during reset: no release
        // R1: the boundary at 135
        step(1, 135, 0, 0, "R1");
        step(1, 136, 0, 0, "R1");
        // R2: the boundary at 150
        step(1, 150, 0, 0, "R2");
        step(1, 151, 0, 0, "R2");
        // R4: the hysteresis band
        step(1, 140, 0, 0, "R4");
        step(1, 120, 0, 0, "R4");
        // R3: release below 120
        step(1, 119, 0, 0, "R3");
        // warning only, then a clear
        step(1, 140, 0, 0, "R1");
        step(1, 121, 0, 0, "R4");
        step(1, 60, 0, 0, "R3");
        // a sweep up and down through the band
        for (int t = 100; t <= 160; t += 3) step(1, t, 0, 0, "R4");
        for (int t = 160; t >= 100; t -= 3) step(1, t, 0, 0, "R3");
        // R9: mute on its own
        step(1, 30, 0, 1, "R9");
        step(1, 30, 0, 0, "R9");
        // R5, R6: a current pulse, then sticky
        step(1, 30, 1, 0, "R5");
        step(1, 30, 0, 0, "R6");
        step(1, 30, 0, 0, "R6");
        step(1, 30, 0, 1, "R6");
        step(1, 30, 0, 1, "R6");
        // R7: release clears
        step(1, 30, 0, 0, "R7");
        step(1, 30, 0, 0, "R7");
        // R8: current still present at release
        step(1, 30, 1, 1, "R8");
        step(1, 30, 1, 0, "R8");
        step(1, 30, 1, 0, "R8");
        step(1, 30, 0, 0, "R8");
        // R10: reset clears the latch and the thermal flags
        step(1, 155, 1, 0, "R10");
        step(0, 155, 0, 0, "R10");
        step(1, 130, 0, 0, "R10");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule